// File: doc/BRIEF.md
# Passive Serial Bitstream Loader

This block pushes a configuration image into a downstream programmable device over a passive serial link. The image arrives one byte at a time on a valid/ready stream, typically from a ROM reader. The block drives an active-low configuration reset towards the device, then a serial clock and a single data line. It watches two open-drain status inputs from the device: an active-low status line that reports an error, and a completion line. Both inputs pass through two-flop synchronisers before the block looks at them.

A session begins with a reset pulse of fixed length and a one-cycle rewind pulse, which tells the byte source to restart at the first byte. The block then waits for the status line to read high. After that it fetches bytes and shifts each one out least significant bit first. The serial clock comes from the system clock through a divider with equal high and low phases. Status and completion are examined only at byte boundaries. A low status restarts the whole session. Completion moves the block into a user phase, where it flags done and keeps the serial clock running so the device can finish its start-up. If the stream hands over its last byte and the device has not yet signalled completion, the block stops clocking and raises an error flag.

Top module: `ps_loader`

## Requirements
- R1: While `rst_n` is low, `cfg_rst_n_o`, `sclk_o`, `s_ready`, `done_o` and `err_o` are all low.
- R2: Every session starts with `cfg_rst_n_o` low for exactly `RST_CYCLES` system clocks, with `rewind_o` high for one cycle. No serial clock edge occurs while `cfg_rst_n_o` is low.
- R3: After the reset pulse, no byte is accepted and no rising edge appears on `sclk_o` until the synchronised status input reads high.
- R4: Each byte goes out bit 0 first, up to bit 7, one bit per rising edge of `sclk_o`. `sdata_o` changes only while `sclk_o` is low.
- R5: While shifting and in the user phase, every high phase of `sclk_o` lasts `HALF` system clocks. Low phases inside a byte and in the user phase also last `HALF`, where `HALF = SYS_HZ/(2*SCLK_HZ)`. No low phase is ever shorter than that.
- R6: If the status input is low at a byte boundary, the block starts a new session (R2) and the image is sent again from its first byte.
- R7: If status is high and the done input is high at a byte boundary, `done_o` rises and stays high. From then on no further byte is accepted, and `sclk_o` keeps toggling (at least 10 rising edges).
- R8: If status is high, done is low, and the byte just sent was not marked last, the next byte is fetched and sent.
- R9: If the byte just sent was marked last and done is still low, `err_o` rises. From then on `sclk_o` stays low and `s_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Byte stream: byte available |
| s_ready | output | 1 | Byte stream: byte taken this cycle |
| s_data | input | 8 | Byte stream: configuration byte |
| s_last | input | 1 | Byte stream: this is the final byte of the image |
| rewind_o | output | 1 | One-cycle pulse: restart the image at its first byte |
| cfg_rst_n_o | output | 1 | Active-low configuration reset to the device |
| sclk_o | output | 1 | Serial configuration clock |
| sdata_o | output | 1 | Serial configuration data |
| stat_n_i | input | 1 | Device status, low means error (asynchronous) |
| done_i | input | 1 | Device completion, high means configured (asynchronous) |
| done_o | output | 1 | Loader in user phase |
| err_o | output | 1 | Image ran out before completion |

## Verification
The bench models the device. It rebuilds bytes from `sdata_o` on each rising edge of `sclk_o`, and it raises its done line once a chosen number of bytes has arrived. A clean load uses mixed bit patterns (0xA5, 0x3C, 0x01, 0x80), which expose bit-order and off-by-one shifting faults, and it also measures the phase lengths. A load with status held low after reset separates a loader that waits from one that clocks blindly. A status drop after the first byte shows whether the restart rewinds the image and repeats the reset pulse. A short image with completion never signalled separates the error stop from a loader that loops or keeps clocking.

// File: rtl/ps_loader_pkg.sv
// Package: shared types for the passive serial loader.
// Assumes: nothing beyond IEEE 1800-2017.
package ps_loader_pkg;

    localparam int BYTE_W = 8;

    // Loader sequencing states.
    typedef enum logic [2:0] {
        ST_RESET = 3'd0,   // drive configuration reset
        ST_WAIT  = 3'd1,   // wait for status high
        ST_FETCH = 3'd2,   // take next byte from stream
        ST_SHIFT = 3'd3,   // serialise current byte
        ST_CHECK = 3'd4,   // byte boundary decision
        ST_USER  = 3'd5,   // configured, free-running clock
        ST_FAIL  = 3'd6    // image exhausted, stopped
    } ld_state_t;

endpackage

// File: rtl/ps_sync.sv
// Module: ps_sync
// Two-flop synchroniser for a vector of independent asynchronous inputs.
// Assumes: each bit is a slow level signal; no bus coherence is implied.
module ps_sync #(
    parameter int           W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_bit
            logic meta_q;
            logic sync_q;

            // Two-stage capture of one asynchronous bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[g];
                    sync_q <= RST_VAL[g];
                end else begin
                    meta_q <= d_i[g];
                    sync_q <= meta_q;
                end
            end

            assign q_o[g] = sync_q;
        end
    endgenerate

endmodule

// File: rtl/ps_clkdiv.sv
// Module: ps_clkdiv
// Emits a one-cycle tick every HALF system clocks while run is high.
// The count restarts from zero whenever run is low, so the first tick
// after run rises comes exactly HALF cycles later.
// Assumes: HALF >= 1.
module ps_clkdiv #(
    parameter int HALF = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;

    // Phase counter, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

    generate
        if (HALF > 1) begin : g_gap_chk
            // R5: two ticks are never adjacent when a phase spans several clocks.
            a_r5_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ps_shifter.sv
// Module: ps_shifter
// Byte holding register that presents bit 0 first and shifts right.
// Assumes: load and shift are never high together.
module ps_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         bit_o
);

    logic [W-1:0] sreg_q;

    // Load a fresh byte or move the next bit into position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= din;
        end else if (shift) begin
            sreg_q <= {1'b0, sreg_q[W-1:1]};
        end
    end

    assign bit_o = sreg_q[0];

endmodule

// File: rtl/ps_loader.sv
// Module: ps_loader (top)
// Loads a byte-stream image into a device over a passive serial link:
// reset pulse, status wait, LSB-first serialisation, byte-boundary
// status/completion checks, restart on error, free-running user clock.
// Assumes: s_data/s_last are stable while s_valid is high; the device
// status lines are asynchronous and slow relative to clk.
module ps_loader
    import ps_loader_pkg::*;
#(
    parameter int SYS_HZ     = 50_000_000,
    parameter int SCLK_HZ    = 5_000_000,
    parameter int RST_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    output logic              rewind_o,
    output logic              cfg_rst_n_o,
    output logic              sclk_o,
    output logic              sdata_o,
    input  logic              stat_n_i,
    input  logic              done_i,
    output logic              done_o,
    output logic              err_o
);

    localparam int HALF_RAW = SYS_HZ / (2 * SCLK_HZ);
    localparam int HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;
    localparam int RST_W    = $clog2(RST_CYCLES + 1);
    localparam int BIT_W    = $clog2(BYTE_W);
    localparam logic [RST_W-1:0] RST_LAST = RST_W'(RST_CYCLES - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

    ld_state_t        state_q;
    logic [RST_W-1:0] rst_cnt_q;
    logic [BIT_W-1:0] bit_cnt_q;
    logic             sclk_q;
    logic             last_q;
    logic             stat_s;
    logic             done_s;
    logic             tick;
    logic             take;
    logic             shift_en;
    logic [1:0]       sync_out;

    // Synchronise device status (bit 1) and completion (bit 0).
    ps_sync #(
        .W       (2),
        .RST_VAL (2'b00)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({stat_n_i, done_i}),
        .q_o   (sync_out)
    );

    assign stat_s = sync_out[1];
    assign done_s = sync_out[0];

    // Half-period tick generator for the serial clock.
    ps_clkdiv #(
        .HALF (HALF)
    ) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((state_q == ST_SHIFT) || (state_q == ST_USER)),
        .tick  (tick)
    );

    assign take     = (state_q == ST_FETCH) && s_valid;
    assign shift_en = (state_q == ST_SHIFT) && tick && sclk_q;

    // Byte serialiser: bit 0 is presented first.
    ps_shifter #(
        .W (BYTE_W)
    ) i_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take),
        .din   (s_data),
        .shift (shift_en),
        .bit_o (sdata_o)
    );

    // Session sequencer and serial clock phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RESET;
            rst_cnt_q <= '0;
            bit_cnt_q <= '0;
            sclk_q    <= 1'b0;
            last_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_RESET: begin
                    sclk_q <= 1'b0;
                    if (rst_cnt_q == RST_LAST) begin
                        rst_cnt_q <= '0;
                        state_q   <= ST_WAIT;
                    end else begin
                        rst_cnt_q <= rst_cnt_q + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (stat_s) begin
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (take) begin
                        last_q    <= s_last;
                        bit_cnt_q <= '0;
                        sclk_q    <= 1'b0;
                        state_q   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_q) begin
                            sclk_q <= 1'b1;
                        end else begin
                            sclk_q <= 1'b0;
                            if (bit_cnt_q == BIT_LAST) begin
                                state_q <= ST_CHECK;
                            end else begin
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                    end
                end
                ST_CHECK: begin
                    if (!stat_s) begin
                        rst_cnt_q <= '0;
                        state_q   <= ST_RESET;
                    end else if (done_s) begin
                        state_q <= ST_USER;
                    end else if (last_q) begin
                        state_q <= ST_FAIL;
                    end else begin
                        state_q <= ST_FETCH;
                    end
                end
                ST_USER: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                    end
                end
                default: begin
                    sclk_q <= 1'b0;
                end
            endcase
        end
    end

    assign s_ready     = (state_q == ST_FETCH);
    assign rewind_o    = (state_q == ST_RESET) && (rst_cnt_q == '0);
    assign cfg_rst_n_o = (state_q != ST_RESET);
    assign sclk_o      = sclk_q;
    assign done_o      = (state_q == ST_USER);
    assign err_o       = (state_q == ST_FAIL);

    // R4: data is held for the whole high phase of the serial clock.
    a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

    // R2: no clocking and no byte intake while the device is held in reset.
    a_r2_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_n_o |-> (!sclk_o && !s_ready));

    // R6: a failed status check at a byte boundary reasserts device reset.
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && !stat_s) |=> (!cfg_rst_n_o && rewind_o));

    // R7: the user phase is final.
    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (done_o && !s_ready));

    // R9: the error stop is final and silent.
    a_r9_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!sclk_o && !s_ready && !done_o));

    // R3: bytes are only taken after the status wait has been left.
    a_r3_no_early_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !stat_s) |=> !s_ready);

endmodule

// File: tb/test_ps_loader.sv
module test_ps_loader;

    localparam int CLK_NS  = 20;
    localparam int SYS_HZ  = 50_000_000;
    localparam int SCLK_HZ = 5_000_000;
    localparam int RST_CYC = 40;
    localparam int HALF    = SYS_HZ / (2 * SCLK_HZ);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_valid, s_ready, s_last;
    logic [7:0] s_data;
    logic       rewind_o, cfg_rst_n_o, sclk_o, sdata_o;
    logic       stat_n_i = 1'b1;
    logic       done_i;
    logic       done_o, err_o;

    int errors = 0;
    int checks = 0;

    // Byte source model.
    logic [7:0] img [0:7];
    int         img_len = 4;
    int         ptr;

    // Device model.
    int         done_after = 1;
    int         rx_bytes;
    int         rx_bit;
    logic [7:0] rx_sh;
    logic [7:0] rx_log [0:7];
    logic       sclk_prev;

    // Monitor.
    int rises, rewinds, rst_run, last_rst_run;
    int hi_run, lo_run, min_hi, max_hi, min_lo, last_lo;
    logic mon_prev;

    always #(CLK_NS/2) clk = ~clk;

    ps_loader #(
        .SYS_HZ     (SYS_HZ),
        .SCLK_HZ    (SCLK_HZ),
        .RST_CYCLES (RST_CYC)
    ) i_ps_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .s_valid     (s_valid),
        .s_ready     (s_ready),
        .s_data      (s_data),
        .s_last      (s_last),
        .rewind_o    (rewind_o),
        .cfg_rst_n_o (cfg_rst_n_o),
        .sclk_o      (sclk_o),
        .sdata_o     (sdata_o),
        .stat_n_i    (stat_n_i),
        .done_i      (done_i),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    assign s_valid = (ptr < img_len);
    assign s_data  = img[ptr[2:0]];
    assign s_last  = (ptr == img_len - 1);
    assign done_i  = (rx_bytes >= done_after);

    // Byte source: advance on handshake, restart on rewind.
    always @(posedge clk) begin
        if (!rst_n || rewind_o) ptr <= 0;
        else if (s_valid && s_ready) ptr <= ptr + 1;
    end

    // Device: capture sdata on each rising serial clock, LSB first.
    always @(posedge clk) begin
        sclk_prev <= sclk_o;
        if (!rst_n || !cfg_rst_n_o) begin
            rx_bytes <= 0;
            rx_bit   <= 0;
            rx_sh    <= 8'h00;
        end else if (sclk_o && !sclk_prev) begin
            if (rx_bit == 7) begin
                rx_log[rx_bytes[2:0]] <= {sdata_o, rx_sh[7:1]};
                rx_bytes <= rx_bytes + 1;
                rx_bit   <= 0;
            end else begin
                rx_sh  <= {sdata_o, rx_sh[7:1]};
                rx_bit <= rx_bit + 1;
            end
        end
    end

    // Monitor: edge counts, phase lengths, reset pulse length.
    always @(negedge clk) begin
        if (!rst_n) begin
            rises <= 0; rewinds <= 0; rst_run <= 0; last_rst_run <= 0;
            hi_run <= 0; lo_run <= 0; min_hi <= 1000; max_hi <= 0;
            min_lo <= 1000; last_lo <= 0; mon_prev <= 1'b0;
        end else begin
            mon_prev <= sclk_o;
            if (rewind_o) rewinds <= rewinds + 1;
            if (!cfg_rst_n_o) rst_run <= rst_run + 1;
            else if (rst_run > 0) begin
                last_rst_run <= rst_run;
                rst_run <= 0;
            end
            if (sclk_o && !mon_prev) begin
                rises <= rises + 1;
                if (lo_run > 0 && lo_run < min_lo) min_lo <= lo_run;
                if (lo_run > 0) last_lo <= lo_run;
                lo_run <= 0;
                hi_run <= 1;
            end else if (!sclk_o && mon_prev) begin
                if (hi_run < min_hi) min_hi <= hi_run;
                if (hi_run > max_hi) max_hi <= hi_run;
                hi_run <= 0;
                lo_run <= (cfg_rst_n_o && rises > 0) ? 1 : 0;
            end else if (sclk_o) begin
                hi_run <= hi_run + 1;
            end else if (lo_run > 0) begin
                lo_run <= lo_run + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic stat_level);
        rst_n    = 1'b0;
        stat_n_i = stat_level;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_done(input int limit);
        for (int i = 0; i < limit && !done_o; i++) @(negedge clk);
    endtask

    // Reset state and clean load with mixed bit patterns.
    task automatic t_clean_load();
        int r0;
        img[0] = 8'hA5; img[1] = 8'h3C; img[2] = 8'h01; img[3] = 8'h80;
        img_len = 4; done_after = 3;
        rst_n = 1'b0; stat_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk({cfg_rst_n_o, sclk_o, s_ready, done_o, err_o} == 5'b0, "R1 outputs in reset",
            int'({cfg_rst_n_o, sclk_o, s_ready, done_o, err_o}), 0);
        rst_n = 1'b1;
        wait_done(5000);
        chk(done_o == 1'b1, "R7 done_o after completion", int'(done_o), 1);
        chk(last_rst_run == RST_CYC, "R2 reset pulse length", last_rst_run, RST_CYC);
        chk(rewinds == 1, "R2 rewind pulses", rewinds, 1);
        chk(rx_log[0] == img[0], "R4 byte0 bit order", int'(rx_log[0]), int'(img[0]));
        chk(rx_log[1] == img[1], "R8 byte1 fetched", int'(rx_log[1]), int'(img[1]));
        chk(rx_log[2] == img[2], "R8 byte2 fetched", int'(rx_log[2]), int'(img[2]));
        r0 = rises;
        repeat (12 * 2 * HALF + 10) @(negedge clk);
        chk(rises - r0 >= 10, "R7 user clocks", rises - r0, 10);
        chk(ptr == 3, "R7 no bytes after done", ptr, 3);
        chk(done_o == 1'b1 && err_o == 1'b0, "R7 done held", int'({done_o, err_o}), 2);
        chk(min_hi == HALF && max_hi == HALF, "R5 high phase", max_hi, HALF);
        chk(min_lo == HALF, "R5 shortest low phase", min_lo, HALF);
        chk(last_lo == HALF, "R5 user low phase", last_lo, HALF);
    endtask

    // Status held low after reset: loader must wait.
    task automatic t_status_wait();
        img[0] = 8'h5A; img[1] = 8'hC3;
        img_len = 2; done_after = 1;
        do_reset(1'b0);
        repeat (300) @(negedge clk);
        chk(rises == 0, "R3 no clock while status low", rises, 0);
        chk(ptr == 0, "R3 no byte taken while status low", ptr, 0);
        stat_n_i = 1'b1;
        wait_done(5000);
        chk(done_o == 1'b1, "R3 load proceeds after status high", int'(done_o), 1);
        chk(rx_log[0] == 8'h5A, "R4 byte after wait", int'(rx_log[0]), 'h5A);
    endtask

    // Status drop at a byte boundary: full restart.
    task automatic t_restart();
        img[0] = 8'h96; img[1] = 8'h0F; img[2] = 8'hE1;
        img_len = 3; done_after = 2;
        do_reset(1'b1);
        for (int i = 0; i < 3000 && rx_bytes < 1; i++) @(negedge clk);
        stat_n_i = 1'b0;
        for (int i = 0; i < 3000 && cfg_rst_n_o; i++) @(negedge clk);
        chk(cfg_rst_n_o == 1'b0, "R6 reset reasserted", int'(cfg_rst_n_o), 0);
        repeat (10) @(negedge clk);
        stat_n_i = 1'b1;
        wait_done(5000);
        chk(rewinds == 2, "R6 second session rewind", rewinds, 2);
        chk(last_rst_run == RST_CYC, "R6 restart pulse length", last_rst_run, RST_CYC);
        chk(rx_log[0] == img[0] && rx_log[1] == img[1], "R6 image resent from start",
            int'(rx_log[0]), int'(img[0]));
        chk(done_o == 1'b1 && ptr == 2, "R6 completes after restart", ptr, 2);
    endtask

    // Image runs out before completion: error stop.
    task automatic t_run_out();
        int r0;
        img[0] = 8'h11; img[1] = 8'h22;
        img_len = 2; done_after = 5;
        do_reset(1'b1);
        for (int i = 0; i < 5000 && !err_o; i++) @(negedge clk);
        chk(err_o == 1'b1 && done_o == 1'b0, "R9 error flag", int'({err_o, done_o}), 2);
        chk(rx_bytes == 2, "R8 both bytes sent", rx_bytes, 2);
        r0 = rises;
        repeat (60) @(negedge clk);
        chk(rises == r0 && sclk_o == 1'b0, "R9 clock stopped", rises - r0, 0);
        chk(s_ready == 1'b0 && ptr == 2 && err_o, "R9 no further intake", ptr, 2);
    endtask

    initial begin
        #(CLK_NS * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_clean_load();
        t_status_wait();
        t_restart();
        t_run_out();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule